// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block gives a processor two independent 48-bit event counters behind a small register bus. Each counter has its own 16-bit control word. The control word picks one of up to 64 event strobe lines by a 6-bit code. Counting only happens while both a run-enable bit and a go bit are set. A self-clearing zero bit resets the count. Event sources deliver single-cycle strobes on a vector indexed by code. A separate prescaled tick input can pace the elapsed-cycle event.

Software prepares a counter in two writes. The first write sets the zero bit. The second writes the event code together with the enable and go bits. To stop a counter, software writes zero to the enable bit and the code field; the count stays readable. Each count is read as a 16-bit upper word and a 32-bit lower word. Writes to the count words are ignored.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset both control words and both counts are zero, and bus_rdata is zero.
- R2: A control word reads back with the event code in bits [5:0], the tick-pacing flag in bit 8, the go bit in bit 14 and the enable bit in bit 15. The zero bit (bit 13) and all other bits read as zero.
- R3: A counter adds one on each clock edge at which its selected strobe is high, but only while its stored enable and go bits are both 1. With only one of the two bits set, the counter does not move.
- R4: The two counters are independent. Each counts only the strobe its own code selects.
- R5: Codes 0x01-0x0b, 0x0d-0x1a, 0x21-0x22, 0x24-0x25 and 0x27-0x29 count evt_strobe[code]. Codes 0x00, 0x0c, 0x1b-0x20, 0x26 and 0x2a-0x3f never count, whatever the strobes do.
- R6: Code 0x23 ignores evt_strobe. It counts every clock edge while bit 8 is 0, and counts each edge with tick_strobe high while bit 8 is 1.
- R7: A control write with bit 13 set makes the count zero at that write edge, and the zero takes precedence over an increment.
- R8: Addresses are mapped as follows. Control word n is at 0x00+4n. The upper count word of counter n is at 0x10+8n, returning count[47:32] in bits [15:0] with bits [31:16] zero. The lower word is at 0x14+8n, returning count[31:0]. Read data appears on the edge that samples bus_rd and holds until the next read.
- R9: Writes to the count words or to unmapped addresses change nothing. Reads of unmapped addresses return zero.
- R10: Writing zero to the enable bit and the code field freezes the count at its value, and later strobes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; bits [15:0] go to control words |
| bus_rdata | output | 32 | Registered read data |
| evt_strobe | input | 64 | Event strobes, bit index equals event code |
| tick_strobe | input | 1 | Prescaled tick for code 0x23 with bit 8 set |

## Verification
A control write takes effect at the edge that samples bus_wr. The new fields first gate counting on the following edge. The zero bit acts on the write edge itself, and an increment at that edge is lost to the stored control. Read data is registered, so it is due one edge after bus_rd is sampled. The bench drives every input on falling edges and samples bus_rdata on the next falling edge. Its expected counts add up the rising edges at which the strobe is high while the old control is still in force. This includes the stop-write edge for the elapsed-cycle code.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int CODE_W  = 6;
  localparam int NUM_EVT = 1 << CODE_W;
  localparam int CTRL_W  = 16;
  localparam int B_EN    = 15;
  localparam int B_GO    = 14;
  localparam int B_ZERO  = 13;
  localparam int B_SLOW  = 8;
  localparam logic [CODE_W-1:0] EV_ELAPSED = 6'h23;

  typedef struct packed {
    logic              en;
    logic              go;
    logic              slow;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  // codes that route to a strobe line
  function automatic logic code_is_live(input logic [CODE_W-1:0] c);
    return (c >= 6'h01 && c <= 6'h0b) || (c >= 6'h0d && c <= 6'h1a) ||
           (c >= 6'h21 && c <= 6'h25) || (c >= 6'h27 && c <= 6'h29);
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_image(input ctrl_t c);
    logic [CTRL_W-1:0] img;
    img = '0;
    img[B_EN]         = c.en;
    img[B_GO]         = c.go;
    img[B_SLOW]       = c.slow;
    img[CODE_W-1:0]   = c.code;
    return img;
  endfunction

  function automatic ctrl_t ctrl_parse(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.en   = w[B_EN];
    c.go   = w[B_GO];
    c.slow = w[B_SLOW];
    c.code = w[CODE_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/pcu_event_sel.sv
module pcu_event_sel
  import pcu_pkg::*;
(
  input  ctrl_t              cfg,
  input  logic [NUM_EVT-1:0] evt_vec,
  input  logic               tick,
  output logic               hit
);
  always_comb begin
    if (cfg.code == EV_ELAPSED) begin
      hit = cfg.slow ? tick : 1'b1;
    end else if (code_is_live(cfg.code)) begin
      hit = evt_vec[cfg.code];
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter
  import pcu_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic [NUM_EVT-1:0] evt_vec,
  input  logic              tick,
  output ctrl_t             cfg_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              zero_pulse
);
  logic hit;

  pcu_event_sel u_sel (
    .cfg     (cfg_q),
    .evt_vec (evt_vec),
    .tick    (tick),
    .hit     (hit)
  );

  assign zero_pulse = cfg_wr & cfg_wdata[B_ZERO];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      count_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= ctrl_parse(cfg_wdata);
      if (zero_pulse) begin
        count_q <= '0;
      end else if (cfg_q.en && cfg_q.go && hit) begin
        count_q <= count_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcu_regbus.sv
module pcu_regbus
  import pcu_pkg::*;
#(
  parameter int NUM_CTR   = 2,
  parameter int CNT_W     = 48,
  parameter int ADDR_W    = 8,
  parameter int CTRL_BASE = 'h00,
  parameter int CTR_BASE  = 'h10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             wr,
  input  logic                             rd,
  input  logic [NUM_CTR-1:0][CTRL_W-1:0]   ctrl_img,
  input  logic [NUM_CTR-1:0][CNT_W-1:0]    counts,
  output logic [NUM_CTR-1:0]               ctrl_wr,
  output logic [31:0]                      rdata
);
  localparam int HI_W = CNT_W - 32;

  logic [31:0] rd_next;

  always_comb begin
    ctrl_wr = '0;
    rd_next = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (addr == ADDR_W'(CTRL_BASE + 4 * n)) begin
        ctrl_wr[n] = wr;
        rd_next    = 32'(ctrl_img[n]);
      end
      if (addr == ADDR_W'(CTR_BASE + 8 * n)) begin
        rd_next = 32'(counts[n][CNT_W-1 -: HI_W]);
      end
      if (addr == ADDR_W'(CTR_BASE + 8 * n + 4)) begin
        rd_next = counts[n][31:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_next;
    end
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
#(
  parameter int NUM_CTR   = 2,
  parameter int CNT_W     = 48,
  parameter int ADDR_W    = 8,
  parameter int CTRL_BASE = 'h00,
  parameter int CTR_BASE  = 'h10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic               tick_strobe
);
  logic [NUM_CTR-1:0]             ctrl_wr;
  logic [NUM_CTR-1:0]             zero_hit;
  logic [NUM_CTR-1:0][CTRL_W-1:0] ctrl_img;
  logic [NUM_CTR-1:0][CNT_W-1:0]  cnt_all;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    ctrl_t cfg;
    pcu_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .cfg_wr     (ctrl_wr[g]),
      .cfg_wdata  (bus_wdata[CTRL_W-1:0]),
      .evt_vec    (evt_strobe),
      .tick       (tick_strobe),
      .cfg_q      (cfg),
      .count_q    (cnt_all[g]),
      .zero_pulse (zero_hit[g])
    );
    assign ctrl_img[g] = ctrl_image(cfg);
  end

  pcu_regbus #(
    .NUM_CTR   (NUM_CTR),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE),
    .CTR_BASE  (CTR_BASE)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .ctrl_img (ctrl_img),
    .counts   (cnt_all),
    .ctrl_wr  (ctrl_wr),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int NUM_CTR   = 2,
  parameter int CNT_W     = 48,
  parameter int ADDR_W    = 8,
  parameter int CTRL_BASE = 'h00,
  parameter int CTR_BASE  = 'h10
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_rd,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_CTR-1:0][15:0]      ctrl_img,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CTR-1:0]            zero_hit
);
  logic live = 1'b0;
  logic is_ctrl, is_hi, is_mapped;

  always_ff @(posedge clk) live <= !rst;

  always_comb begin
    is_ctrl = 1'b0;
    is_hi   = 1'b0;
    is_mapped = 1'b0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (bus_addr == ADDR_W'(CTRL_BASE + 4 * n)) is_ctrl = 1'b1;
      if (bus_addr == ADDR_W'(CTR_BASE + 8 * n)) is_hi = 1'b1;
      if (bus_addr == ADDR_W'(CTR_BASE + 8 * n + 4)) is_mapped = 1'b1;
    end
    is_mapped = is_mapped | is_ctrl | is_hi;
  end

  a_r1_reset_rdata: assert property (@(posedge clk) rst |=> bus_rdata == 32'd0);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    live && $past(bus_rd) && !$past(is_mapped) |-> bus_rdata == 32'd0);

  a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
    live && $past(bus_rd) && $past(is_ctrl) |->
      bus_rdata[31:16] == 16'd0 && bus_rdata[13:9] == 5'd0 && bus_rdata[7:6] == 2'd0);

  a_r8_high_upper_zero: assert property (@(posedge clk) disable iff (rst)
    live && $past(bus_rd) && $past(is_hi) |-> bus_rdata[31:CNT_W-32] == '0);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
      live |-> cnt_all[i] == $past(cnt_all[i]) ||
               cnt_all[i] == $past(cnt_all[i]) + 1'b1 || cnt_all[i] == '0);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
      live && !($past(ctrl_img[i][15]) && $past(ctrl_img[i][14])) && !$past(zero_hit[i])
        |-> cnt_all[i] == $past(cnt_all[i]));

    a_r7_zero_wins: assert property (@(posedge clk) disable iff (rst)
      live && $past(zero_hit[i]) |-> cnt_all[i] == '0);
  end
endmodule

bind perf_counter_unit pcu_checker #(
  .NUM_CTR   (NUM_CTR),
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W),
  .CTRL_BASE (CTRL_BASE),
  .CTR_BASE  (CTR_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ctrl_img  (ctrl_img),
  .cnt_all   (cnt_all),
  .zero_hit  (zero_hit)
);

// File: tb/perf_counter_unit_bench.sv
module perf_counter_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] evt_strobe = '0;
  logic        tick_strobe = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  perf_counter_unit u_perf_counter_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe),
    .tick_strobe(tick_strobe)
  );

  // [15:8] expected count, [6] tick-pacing flag, [5:0] code
  localparam int NV = 15;
  localparam logic [15:0] TBL [NV] = '{
    16'h0501, 16'h050b, 16'h000c, 16'h050d, 16'h051a, 16'h001b, 16'h0020,
    16'h0521, 16'h0026, 16'h0529, 16'h002a, 16'h003f, 16'h0000, 16'h0623,
    16'h0063
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_all(input int n);
    evt_strobe = '1;
    repeat (n) @(negedge clk);
    evt_strobe = '0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] d1;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    for (int a = 0; a < 32; a += 4) begin
      bus_read(8'(a), d);
      check("R1 reset read", d, 32'h0);
    end

    // table: code classes on counter 0, all strobes high for 5 edges
    for (int i = 0; i < NV; i++) begin
      logic [15:0] go;
      go = 16'hC000 | (TBL[i][6] ? 16'h0100 : 16'h0000) | 16'(TBL[i][5:0]);
      bus_write(8'h00, 32'h2000);
      bus_read(8'h14, d);
      check("R7 zero before run", d, 32'h0);
      bus_write(8'h00, 32'(go));
      pulse_all(5);
      bus_write(8'h00, 32'h0);
      bus_read(8'h14, d);
      check(TBL[i][5:0] == 6'h23 ? "R6 elapsed code" : "R5 code class",
            d, 32'(TBL[i][15:8]));
    end

    // R2 readback
    bus_write(8'h04, 32'h0000FFFF);
    bus_read(8'h04, d);
    check("R2 ctrl readback", d, 32'h0000C13F);
    bus_write(8'h04, 32'h0);

    // R3 enable only / go only
    bus_write(8'h00, 32'h2000);
    bus_write(8'h00, 32'h8010);
    pulse_all(4);
    bus_write(8'h00, 32'h4010);
    pulse_all(4);
    bus_write(8'h00, 32'h0);
    bus_read(8'h14, d);
    check("R3 needs enable and go", d, 32'h0);

    // R4 independence: ctr0 on 0x10, ctr1 on 0x08
    bus_write(8'h00, 32'h2000);
    bus_write(8'h04, 32'h2000);
    bus_write(8'h00, 32'hC010);
    bus_write(8'h04, 32'hC008);
    evt_strobe[16] = 1'b1;
    repeat (3) @(negedge clk);
    evt_strobe = '0;
    evt_strobe[8] = 1'b1;
    repeat (7) @(negedge clk);
    evt_strobe = '0;
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, 32'h0);
    bus_read(8'h14, d);
    bus_read(8'h1C, d1);
    check("R4 counter0", d, 32'd3);
    check("R4 counter1", d1, 32'd7);
    bus_read(8'h18, d);
    check("R8 high word", d, 32'h0);
    bus_read(8'h10, d);
    check("R8 high word ctr0", d, 32'h0);

    // R9 writes to count words and unmapped addresses ignored
    bus_write(8'h1C, 32'hFFFFFFFF);
    bus_write(8'h18, 32'hFFFFFFFF);
    bus_write(8'h08, 32'h0000FFFF);
    bus_read(8'h1C, d);
    check("R9 count write ignored", d, 32'd7);
    bus_read(8'h08, d);
    check("R9 unmapped read", d, 32'h0);
    bus_read(8'h30, d);
    check("R9 unmapped read high", d, 32'h0);
    bus_read(8'h04, d);
    check("R9 ctrl untouched", d, 32'h0);

    // R6 tick pacing
    bus_write(8'h04, 32'h2000);
    bus_write(8'h04, 32'hC123);
    for (int k = 0; k < 4; k++) begin
      tick_strobe = 1'b1; @(negedge clk);
      tick_strobe = 1'b0; @(negedge clk);
    end
    bus_write(8'h04, 32'h0);
    bus_read(8'h1C, d);
    check("R6 tick paced", d, 32'd4);

    // R10 stop keeps value
    bus_write(8'h00, 32'h2000);
    bus_write(8'h00, 32'hC010);
    pulse_all(5);
    bus_write(8'h00, 32'h4000);
    pulse_all(4);
    bus_read(8'h14, d);
    check("R10 frozen count", d, 32'd5);
    bus_read(8'h00, d);
    check("R10 stopped ctrl", d, 32'h4000);

    // R7 zero bit clears a held count
    bus_write(8'h00, 32'h2000);
    bus_read(8'h14, d);
    check("R7 zero clears", d, 32'h0);
    bus_read(8'h00, d);
    check("R2 zero bit reads 0", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule